// File: doc/BRIEF.md
# Multi-cycle integer divide and remainder unit

This block performs 32-bit integer division for a processor's divide instruction group. One unit serves eight operation codes. It returns either the quotient or the remainder. The operation can be signed or unsigned, and the divisor comes either from a second register operand or from a 16-bit immediate. The low three code bits choose among these variants. The upper three bits must carry the divide-group pattern `001`; any other code is not accepted.

A caller raises `start` for one cycle while `busy` is low. It holds the code and operands on the inputs during that cycle. When the divisor is non-zero, the unit runs a radix-2 restoring iteration on operand magnitudes. This takes one setup cycle, 32 iteration cycles and one sign fix-up cycle. It then pulses `done` and `wr_en` together with the result. When the divisor is zero, the unit skips the iteration. It pulses `done` together with `div_fault` in the next cycle and leaves the result untouched.

Top module: `divrem_unit`

## Requirements
- R1: `op` bit 0 set takes the extended immediate as divisor, otherwise `src_b`. Bit 1 set selects unsigned arithmetic. Bit 2 set returns the remainder instead of the quotient.
- R2: For signed codes the 16-bit immediate is sign-extended to 32 bits. For unsigned codes it is zero-extended.
- R3: A signed quotient is rounded toward zero.
- R4: A signed remainder carries the sign of the dividend, so that dividend = quotient × divisor + remainder.
- R5: Unsigned codes treat both operands as unsigned 32-bit values.
- R6: A start whose selected divisor is zero gives `done` and `div_fault` high in the following cycle. In that cycle `wr_en` stays low, and `result` keeps its previous value.
- R7: Signed 0x80000000 divided by -1 gives quotient 0x80000000 and remainder 0, with no fault.
- R8: For a non-zero divisor, `done` and `wr_en` rise together for one cycle, 34 clock edges after the edge that accepts start. `busy` is high for exactly the 34 cycles in between.
- R9: A start raised while `busy` is high is ignored. The running operation completes with its own result, and no second completion follows.
- R10: After reset, `busy`, `done`, `wr_en` and `div_fault` are low and `result` is zero.
- R11: A start raised in the cycle where `done` is high is accepted.
- R12: A start whose `op` bits 5..3 differ from `001` is ignored: no `busy`, no `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a new operation (one cycle) |
| op | input | 6 | Operation code of the divide group |
| src_a | input | 32 | Dividend register value |
| src_b | input | 32 | Divisor register value |
| imm | input | 16 | Immediate divisor field |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | Completion pulse |
| result | output | 32 | Quotient or remainder |
| wr_en | output | 1 | Result register write enable |
| div_fault | output | 1 | Divide-by-zero fault, coincides with done |

## Verification
A completion pulse and a newly accepted start can fall in the same cycle, because `busy` is already low while `done` is high. The bench launches a second operation in exactly that cycle, once after a normal completion and once after a fault completion. It then checks that the second result is correct and arrives with the full latency. Start requests made during `busy` are judged by showing that the first result is unchanged and that no extra completion appears afterwards.

// File: rtl/divrem_pkg.sv
package divrem_pkg;

   typedef struct packed {
      logic use_imm;
      logic is_unsigned;
      logic want_rem;
   } dr_mode_t;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_SETUP = 2'd1,
      ST_ITER  = 2'd2,
      ST_FIX   = 2'd3
   } dr_state_t;

   localparam logic [2:0] DIV_GROUP = 3'b001;

   function automatic dr_mode_t decode_mode(input logic [2:0] sel);
      dr_mode_t m;
      m.use_imm     = sel[0];
      m.is_unsigned = sel[1];
      m.want_rem    = sel[2];
      return m;
   endfunction

endpackage

// File: rtl/divrem_operand.sv
module divrem_operand
   import divrem_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int IMM_W  = 16
) (
   input  dr_mode_t            mode,
   input  logic [DATA_W-1:0]   src_a,
   input  logic [DATA_W-1:0]   src_b,
   input  logic [IMM_W-1:0]    imm,
   output logic [DATA_W-1:0]   dividend,
   output logic [DATA_W-1:0]   divisor,
   output logic                divisor_zero
);

   logic [DATA_W-1:0] imm_ext;

   generate
      if (IMM_W < DATA_W) begin : g_ext
         localparam int PAD_W = DATA_W - IMM_W;
         always_comb begin
            if (mode.is_unsigned)
               imm_ext = {{PAD_W{1'b0}}, imm};
            else
               imm_ext = {{PAD_W{imm[IMM_W-1]}}, imm};
         end
      end else begin : g_noext
         assign imm_ext = imm;
      end
   endgenerate

   assign dividend     = src_a;
   assign divisor      = mode.use_imm ? imm_ext : src_b;
   assign divisor_zero = (divisor == '0);

endmodule

// File: rtl/divrem_core.sv
module divrem_core #(
   parameter int DATA_W = 32
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                load,
   input  logic                step,
   input  logic [DATA_W-1:0]   mag_dividend,
   input  logic [DATA_W-1:0]   mag_divisor,
   output logic [DATA_W-1:0]   quot,
   output logic [DATA_W-1:0]   rem
);

   logic [DATA_W-1:0] quot_q, rem_q, dvs_q;
   logic [DATA_W:0]   shifted, trial;

   always_comb begin
      shifted = {rem_q, quot_q[DATA_W-1]};
      trial   = shifted - {1'b0, dvs_q};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         quot_q <= '0;
         rem_q  <= '0;
         dvs_q  <= '0;
      end else if (load) begin
         quot_q <= mag_dividend;
         rem_q  <= '0;
         dvs_q  <= mag_divisor;
      end else if (step) begin
         if (!trial[DATA_W]) begin
            rem_q  <= trial[DATA_W-1:0];
            quot_q <= {quot_q[DATA_W-2:0], 1'b1};
         end else begin
            rem_q  <= shifted[DATA_W-1:0];
            quot_q <= {quot_q[DATA_W-2:0], 1'b0};
         end
      end
   end

   assign quot = quot_q;
   assign rem  = rem_q;

endmodule

// File: rtl/divrem_fixup.sv
module divrem_fixup #(
   parameter int DATA_W = 32
) (
   input  logic [DATA_W-1:0] quot,
   input  logic [DATA_W-1:0] rem,
   input  logic              neg_quot,
   input  logic              neg_rem,
   input  logic              want_rem,
   output logic [DATA_W-1:0] fixed
);

   logic [DATA_W-1:0] q_signed, r_signed;

   always_comb begin
      q_signed = neg_quot ? (~quot + 1'b1) : quot;
      r_signed = neg_rem  ? (~rem  + 1'b1) : rem;
      fixed    = want_rem ? r_signed : q_signed;
   end

endmodule

// File: rtl/divrem_unit.sv
module divrem_unit
   import divrem_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int IMM_W  = 16,
   parameter int OP_W   = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [OP_W-1:0]   op,
   input  logic [DATA_W-1:0] src_a,
   input  logic [DATA_W-1:0] src_b,
   input  logic [IMM_W-1:0]  imm,
   output logic              busy,
   output logic              done,
   output logic [DATA_W-1:0] result,
   output logic              wr_en,
   output logic              div_fault
);

   localparam int CNT_W = $clog2(DATA_W);
   localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(DATA_W - 1);

   generate
      if (DATA_W < 2 || IMM_W > DATA_W || IMM_W < 1) begin : g_bad_width
         $error("divrem_unit: unsupported DATA_W/IMM_W combination");
      end
      if (OP_W != 6) begin : g_bad_op
         $error("divrem_unit: operation code must be 6 bits");
      end
   endgenerate

   dr_state_t         state_q;
   dr_mode_t          mode_in, mode_q;
   logic [DATA_W-1:0] dividend_in, divisor_in;
   logic              divisor_zero;
   logic [DATA_W-1:0] opa_q, opb_q;
   logic              neg_q_q, neg_r_q;
   logic [CNT_W-1:0]  cnt_q;
   logic              accept, in_group;
   logic              a_neg, b_neg;
   logic [DATA_W-1:0] mag_a, mag_b;
   logic [DATA_W-1:0] core_quot, core_rem, fixed;
   logic              core_load, core_step;

   assign mode_in  = decode_mode(op[2:0]);
   assign in_group = (op[OP_W-1:3] == DIV_GROUP);
   assign accept   = start && (state_q == ST_IDLE) && in_group;

   divrem_operand #(.DATA_W(DATA_W), .IMM_W(IMM_W)) opnd_i (
      .mode         (mode_in),
      .src_a        (src_a),
      .src_b        (src_b),
      .imm          (imm),
      .dividend     (dividend_in),
      .divisor      (divisor_in),
      .divisor_zero (divisor_zero)
   );

   always_comb begin
      a_neg = !mode_q.is_unsigned && opa_q[DATA_W-1];
      b_neg = !mode_q.is_unsigned && opb_q[DATA_W-1];
      mag_a = a_neg ? (~opa_q + 1'b1) : opa_q;
      mag_b = b_neg ? (~opb_q + 1'b1) : opb_q;
   end

   assign core_load = (state_q == ST_SETUP);
   assign core_step = (state_q == ST_ITER);

   divrem_core #(.DATA_W(DATA_W)) core_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .load         (core_load),
      .step         (core_step),
      .mag_dividend (mag_a),
      .mag_divisor  (mag_b),
      .quot         (core_quot),
      .rem          (core_rem)
   );

   divrem_fixup #(.DATA_W(DATA_W)) fix_i (
      .quot     (core_quot),
      .rem      (core_rem),
      .neg_quot (neg_q_q),
      .neg_rem  (neg_r_q),
      .want_rem (mode_q.want_rem),
      .fixed    (fixed)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         mode_q    <= '0;
         opa_q     <= '0;
         opb_q     <= '0;
         neg_q_q   <= 1'b0;
         neg_r_q   <= 1'b0;
         cnt_q     <= '0;
         result    <= '0;
         done      <= 1'b0;
         wr_en     <= 1'b0;
         div_fault <= 1'b0;
      end else begin
         done      <= 1'b0;
         wr_en     <= 1'b0;
         div_fault <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (accept) begin
                  if (divisor_zero) begin
                     done      <= 1'b1;
                     div_fault <= 1'b1;
                  end else begin
                     mode_q  <= mode_in;
                     opa_q   <= dividend_in;
                     opb_q   <= divisor_in;
                     state_q <= ST_SETUP;
                  end
               end
            end
            ST_SETUP: begin
               neg_q_q <= a_neg ^ b_neg;
               neg_r_q <= a_neg;
               cnt_q   <= '0;
               state_q <= ST_ITER;
            end
            ST_ITER: begin
               cnt_q <= cnt_q + 1'b1;
               if (cnt_q == LAST_STEP)
                  state_q <= ST_FIX;
            end
            ST_FIX: begin
               result  <= fixed;
               done    <= 1'b1;
               wr_en   <= 1'b1;
               state_q <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign busy = (state_q != ST_IDLE);

endmodule

// File: rtl/divrem_unit_chk.sv
module divrem_unit_chk #(
   parameter int DATA_W = 32,
   parameter int IMM_W  = 16,
   parameter int OP_W   = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic [OP_W-1:0]   op,
   input logic [DATA_W-1:0] src_b,
   input logic [IMM_W-1:0]  imm,
   input logic              busy,
   input logic              done,
   input logic [DATA_W-1:0] result,
   input logic              wr_en,
   input logic              div_fault
);

   localparam int BC_W = $clog2(DATA_W + 4) + 1;

   logic [BC_W-1:0] busy_cnt;
   logic            zero_sel, grp_ok;

   assign zero_sel = op[0] ? (imm == '0) : (src_b == '0);
   assign grp_ok   = (op[OP_W-1:3] == 3'b001);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         busy_cnt <= '0;
      else if (start && !busy)
         busy_cnt <= '0;
      else if (busy)
         busy_cnt <= busy_cnt + 1'b1;
   end

   p_fault_no_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
      div_fault |-> (done && !wr_en));

   p_zero_faults_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy && grp_ok && zero_sel) |=> (done && div_fault));

   p_fault_keeps_result_r6: assert property (@(posedge clk) disable iff (!rst_n)
      div_fault |-> $stable(result));

   p_write_with_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (done && !busy));

   p_write_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> !wr_en);

   p_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (busy_cnt == BC_W'(DATA_W + 2)));

   p_result_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> $stable(result));

   p_foreign_ignored_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy && !grp_ok) |=> (!busy && !done));

endmodule

bind divrem_unit divrem_unit_chk #(.DATA_W(DATA_W), .IMM_W(IMM_W), .OP_W(OP_W)) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .start     (start),
   .op        (op),
   .src_b     (src_b),
   .imm       (imm),
   .busy      (busy),
   .done      (done),
   .result    (result),
   .wr_en     (wr_en),
   .div_fault (div_fault)
);

// File: tb/divrem_unit_tb_top.sv
module divrem_unit_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int LAT_OK     = 35;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [5:0]  op = '0;
   logic [31:0] src_a = '0, src_b = '0;
   logic [15:0] imm = '0;
   logic        busy, done, wr_en, div_fault;
   logic [31:0] result;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   divrem_unit dut_i (
      .clk(clk), .rst_n(rst_n), .start(start), .op(op),
      .src_a(src_a), .src_b(src_b), .imm(imm),
      .busy(busy), .done(done), .result(result),
      .wr_en(wr_en), .div_fault(div_fault)
   );

   task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] pick_div(input logic [5:0] c, input logic [31:0] b, input logic [15:0] i);
      if (!c[0]) return b;
      if (c[1]) return {16'h0, i};
      return {{16{i[15]}}, i};
   endfunction

   function automatic logic [31:0] ref_calc(input logic [5:0] c, input logic [31:0] a,
                                            input logic [31:0] b, input logic [15:0] i);
      logic [31:0] d;
      logic signed [63:0] sa, sd;
      d = pick_div(c, b, i);
      if (c[1]) return c[2] ? (a % d) : (a / d);
      sa = {{32{a[31]}}, a};
      sd = {{32{d[31]}}, d};
      return c[2] ? 32'(sa % sd) : 32'(sa / sd);
   endfunction

   task automatic launch(input logic [5:0] c, input logic [31:0] a, input logic [31:0] b, input logic [15:0] i);
      op = c; src_a = a; src_b = b; imm = i; start = 1'b1;
   endtask

   task automatic wait_done(output int cyc);
      cyc = 0;
      do begin
         @(negedge clk);
         start = 1'b0;
         cyc++;
      end while (!done && cyc < 100);
   endtask

   task automatic run_op(input string tag, input logic [5:0] c, input logic [31:0] a,
                         input logic [31:0] b, input logic [15:0] i);
      int cyc;
      logic [31:0] prev, exp;
      bit zero;
      prev = result;
      zero = (pick_div(c, b, i) == 32'h0);
      launch(c, a, b, i);
      wait_done(cyc);
      if (zero) begin
         check(cyc == 1, {tag, " R6 fault latency"}, 32'(cyc), 32'd1);
         check(done && div_fault && !wr_en, {tag, " R6 fault flags"},
               {29'h0, done, div_fault, wr_en}, 32'h6);
         check(result == prev, {tag, " R6 result kept"}, result, prev);
      end else begin
         exp = ref_calc(c, a, b, i);
         check(cyc == LAT_OK, {tag, " R8 latency"}, 32'(cyc), 32'(LAT_OK));
         check(wr_en && !div_fault, {tag, " R8 write"}, {30'h0, wr_en, div_fault}, 32'h2);
         check(result == exp, {tag, " result"}, result, exp);
         @(negedge clk);
         check(!done && !wr_en, {tag, " R8 single pulse"}, {30'h0, done, wr_en}, 32'h0);
      end
   endtask

   task automatic t_reset;
      check(!busy && !done && !wr_en && !div_fault, "R10 reset flags",
            {28'h0, busy, done, wr_en, div_fault}, 32'h0);
      check(result == 32'h0, "R10 reset result", result, 32'h0);
   endtask

   task automatic t_signs;
      run_op("R3 7/2",        6'b001000, 32'd7, 32'd2, 16'h0);
      run_op("R3 -7/2",       6'b001000, -32'sd7, 32'd2, 16'h0);
      run_op("R3 7/-2",       6'b001000, 32'd7, -32'sd2, 16'h0);
      run_op("R4 -7%2",       6'b001100, -32'sd7, 32'd2, 16'h0);
      run_op("R4 7%-2",       6'b001100, 32'd7, -32'sd2, 16'h0);
      run_op("R4 -7%-2",      6'b001100, -32'sd7, -32'sd2, 16'h0);
      run_op("R5 unsigned q", 6'b001010, 32'hFFFF_FFFF, 32'd2, 16'h0);
      run_op("R5 unsigned r", 6'b001110, 32'hFFFF_FFFF, 32'h8000_0001, 16'h0);
   endtask

   task automatic t_immediate;
      run_op("R2 sext imm q",  6'b001001, 32'd100, 32'd7, 16'hFFFE);
      run_op("R2 zext imm q",  6'b001011, 32'd100, 32'd7, 16'hFFFE);
      run_op("R2 sext imm r",  6'b001101, -32'sd100, 32'd7, 16'hFFF9);
      run_op("R2 zext imm r",  6'b001111, 32'd1000000, 32'd7, 16'hFFFE);
      run_op("R1 reg ignores imm", 6'b001000, 32'd100, 32'd5, 16'h0000);
   endtask

   task automatic t_overflow;
      run_op("R7 min/-1 q",     6'b001000, 32'h8000_0000, 32'hFFFF_FFFF, 16'h0);
      run_op("R7 min/-1 r",     6'b001100, 32'h8000_0000, 32'hFFFF_FFFF, 16'h0);
      run_op("R7 min/imm -1 q", 6'b001001, 32'h8000_0000, 32'h0, 16'hFFFF);
   endtask

   task automatic t_zero;
      run_op("R6 reg zero",     6'b001000, 32'd5, 32'h0, 16'h1234);
      run_op("R6 imm zero",     6'b001101, 32'd5, 32'd3, 16'h0000);
      run_op("R6 uimm zero",    6'b001011, 32'hFFFF_FFFF, 32'd9, 16'h0000);
      run_op("R6 ureg zero",    6'b001110, 32'd5, 32'h0, 16'h0001);
   endtask

   task automatic t_busy_ignore;
      int cyc;
      logic [31:0] exp;
      bit extra;
      exp = ref_calc(6'b001000, 32'd1000, 32'd10, 16'h0);
      launch(6'b001000, 32'd1000, 32'd10, 16'h0);
      @(negedge clk); start = 1'b0;
      repeat (4) @(negedge clk);
      launch(6'b001110, 32'd77, 32'd0, 16'h0);
      cyc = 5;
      do begin
         @(negedge clk);
         start = 1'b0;
         cyc++;
      end while (!done && cyc < 100);
      check(cyc == LAT_OK, "R9 latency unaffected", 32'(cyc), 32'(LAT_OK));
      check(!div_fault && result == exp, "R9 first result kept", result, exp);
      extra = 1'b0;
      repeat (40) begin
         @(negedge clk);
         if (done || busy) extra = 1'b1;
      end
      check(!extra, "R9 no second completion", {31'h0, extra}, 32'h0);
   endtask

   task automatic t_back_to_back;
      int cyc;
      logic [31:0] exp;
      launch(6'b001000, 32'd90, 32'd9, 16'h0);
      wait_done(cyc);
      exp = ref_calc(6'b001100, 32'd95, 32'd9, 16'h0);
      launch(6'b001100, 32'd95, 32'd9, 16'h0);
      wait_done(cyc);
      check(cyc == LAT_OK && wr_en, "R11 start in done cycle", 32'(cyc), 32'(LAT_OK));
      check(result == exp, "R11 second result", result, exp);
      launch(6'b001000, 32'd5, 32'd0, 16'h0);
      wait_done(cyc);
      exp = ref_calc(6'b001010, 32'd40, 32'd8, 16'h0);
      launch(6'b001010, 32'd40, 32'd8, 16'h0);
      wait_done(cyc);
      check(cyc == LAT_OK && result == exp, "R11 start in fault cycle", result, exp);
   endtask

   task automatic t_foreign;
      bit seen;
      launch(6'b000000, 32'd10, 32'd0, 16'h0);
      seen = 1'b0;
      repeat (40) begin
         @(negedge clk);
         start = 1'b0;
         if (busy || done) seen = 1'b1;
      end
      check(!seen, "R12 foreign code ignored", {31'h0, seen}, 32'h0);
   endtask

   task automatic t_random;
      for (int k = 0; k < 8; k++) begin
         for (int n = 0; n < 12; n++) begin
            logic [31:0] a, b;
            logic [15:0] i;
            a = $urandom;
            b = (n % 3 == 0) ? ($urandom & 32'hFF) : $urandom;
            i = $urandom;
            if (n == 5) a = 32'h8000_0000;
            run_op($sformatf("R1 random code %0d", k), {3'b001, 3'(k)}, a, b, i);
         end
      end
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_signs();
      t_immediate();
      t_overflow();
      t_zero();
      t_busy_ignore();
      t_back_to_back();
      t_foreign();
      t_random();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule